// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block is the digital control front end of a five-bit step attenuator, rebuilt for a synchronous clock domain. It takes a parallel attenuation word, a latch-enable line and a power-up select bit. It produces the registered attenuation state and the same state counted in half-dB units. It also raises a sticky flag when a latch-enable pulse is too short.

The block has two modes. While latch enable is high, the state is transparent and follows the control word. While latch enable is low, the state holds, and a high-then-low pulse on latch enable loads a new word. Reset stands in for power-up. Once reset is released, the block waits until its input synchronisers have filled, then loads a default state. That default depends on latch enable and the select bit.

All asynchronous inputs pass through a two-stage synchroniser. A change at the inputs therefore reaches the state on the third rising clock edge. Software clears the violation flag with a single-cycle clear input.

Top module: `step_atten_ctrl`

## Requirements
- R1: State bit 4 weighs 8 dB, bit 3 weighs 4 dB, bit 2 weighs 2 dB, bit 1 weighs 1 dB and bit 0 weighs 0.5 dB. All 32 codes are legal, and `half_db_o` equals the state read as an unsigned number from 0 to 31.
- R2: While `le_i` is high, the state follows `ctl_i`. A change at the inputs appears on the third rising edge after it.
- R3: While `le_i` is low, changes on `ctl_i` leave the state unchanged.
- R4: A high-then-low pulse on `le_i` loads the word present on `ctl_i` during the pulse. That word is then held after `le_i` returns low.
- R5: While `rst_ni` is low, the state is 0 and the violation flag is 0.
- R6: After reset, if `le_i` is low and `pup_sel_i` is 0, the state becomes 5'b00000 (0 dB) on the third rising edge.
- R7: After reset, if `le_i` is low and `pup_sel_i` is 1, the state becomes 5'b10000 (8 dB).
- R8: After reset, if `le_i` is high, the state becomes `ctl_i` and `pup_sel_i` has no effect.
- R9: A latch-enable high time shorter than MIN_PW_CYC clock cycles (default 4) sets `pw_viol_o` once latch enable falls. A high time of MIN_PW_CYC cycles or more does not set it.
- R10: `pw_viol_o` stays set until `pw_clr_i` is high for a cycle. A violation detected in that same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, models power-up |
| ctl_i | input | 5 | Parallel attenuation control word (asynchronous) |
| le_i | input | 1 | Latch enable: high is transparent, the falling edge latches (asynchronous) |
| pup_sel_i | input | 1 | Selects the power-up default when latch enable is low (asynchronous) |
| pw_clr_i | input | 1 | Synchronous clear of the pulse-width violation flag |
| state_o | output | 5 | Registered attenuation state |
| half_db_o | output | 5 | Attenuation in 0.5 dB units |
| pw_viol_o | output | 1 | Sticky flag for a latch-enable pulse that was too short |

## Verification
A vector table drives latched loads that pair single-bit, all-ones, all-zero and mixed words with pulse widths below, at and above the limit. These vectors separate two failures: a wrong load or a swapped bit weight, and a wrong decision at the pulse-width threshold. After each pulse the control word is changed to its complement while latch enable is low, which shows whether the state truly holds. Directed tests then step the control word while latch enable is high to confirm transparency. They also repeat reset under all three power-up conditions, which tells the select-bit defaults apart from the transparent start. Finally they confirm that the flag survives until cleared.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATT_BITS = 5;
  typedef logic [ATT_BITS-1:0] att_code_t;

  localparam att_code_t ATT_ZERO = '0;
  localparam att_code_t ATT_MSB  = att_code_t'(1) << (ATT_BITS-1);

  // power-up default: transparent start takes the word, else select picks MSB or zero
  function automatic att_code_t boot_code(input logic le, input logic sel, input att_code_t word);
    if (le) return word;
    return sel ? ATT_MSB : ATT_ZERO;
  endfunction
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/atten_pw_mon.sv
module atten_pw_mon #(
  parameter int MIN_PW_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic le_s_i,
  input  logic clr_i,
  output logic viol_o
);
  localparam int CNT_W = $clog2(MIN_PW_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_PW_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             viol_q;
  logic             fall, short_hit;

  // a nonzero count while le is low marks the falling-edge cycle
  assign fall      = !le_s_i && (cnt_q != '0);
  assign short_hit = fall && (cnt_q < CNT_SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      if (!le_s_i)              cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (short_hit)   viol_q <= 1'b1;
      else if (clr_i)  viol_q <= 1'b0;
    end
  end

  assign viol_o = viol_q;

  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !clr_i) |=> viol_q); // R10
  AST_SHORT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_hit |=> viol_q); // R9
  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !short_hit) |=> !viol_q); // R10
endmodule

// File: rtl/atten_state.sv
module atten_state
  import atten_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  att_code_t ctl_s_i,
  input  logic      le_s_i,
  input  logic      pup_s_i,
  output att_code_t state_o
);
  localparam int BOOT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [BOOT_W-1:0] BOOT_LAST = BOOT_W'(SYNC_STAGES);

  att_code_t         state_q;
  logic              le_q, init_q;
  logic [BOOT_W-1:0] boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ATT_ZERO;
      le_q    <= 1'b0;
      init_q  <= 1'b0;
      boot_q  <= '0;
    end else begin
      le_q <= le_s_i;
      if (!init_q) begin
        // wait for synchronisers to fill before sampling power-up pins
        if (boot_q == BOOT_LAST) begin
          init_q  <= 1'b1;
          state_q <= boot_code(le_s_i, pup_s_i, ctl_s_i);
        end else begin
          boot_q <= boot_q + 1'b1;
        end
      end else if (le_s_i || le_q) begin
        state_q <= ctl_s_i;
      end
    end
  end

  assign state_o = state_q;

  AST_FOLLOW_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && le_s_i) |=> (state_q == $past(ctl_s_i))); // R2
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !le_s_i && !le_q) |=> $stable(state_q)); // R3
  AST_BOOT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(init_q) && !$past(le_s_i)) |-> (state_q == ($past(pup_s_i) ? ATT_MSB : ATT_ZERO))); // R7
  AST_BOOT_LE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(init_q) && $past(le_s_i)) |-> (state_q == $past(ctl_s_i))); // R8
  AST_PRE_BOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |-> (state_q == ATT_ZERO)); // R5
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW_CYC  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ATT_BITS-1:0] ctl_i,
  input  logic                le_i,
  input  logic                pup_sel_i,
  input  logic                pw_clr_i,
  output logic [ATT_BITS-1:0] state_o,
  output logic [ATT_BITS-1:0] half_db_o,
  output logic                pw_viol_o
);
  localparam int SW = ATT_BITS + 2;

  logic [SW-1:0] raw, syn;
  att_code_t     ctl_s, state;
  logic          le_s, pup_s;

  assign raw = {pup_sel_i, le_i, ctl_i};

  atten_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign ctl_s = syn[ATT_BITS-1:0];
  assign le_s  = syn[ATT_BITS];
  assign pup_s = syn[ATT_BITS+1];

  atten_state #(.SYNC_STAGES(SYNC_STAGES)) i_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_s_i(ctl_s),
    .le_s_i (le_s),
    .pup_s_i(pup_s),
    .state_o(state)
  );

  atten_pw_mon #(.MIN_PW_CYC(MIN_PW_CYC)) i_pw_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_s_i(le_s),
    .clr_i (pw_clr_i),
    .viol_o(pw_viol_o)
  );

  assign state_o   = state;
  assign half_db_o = state; // R1: one LSB is 0.5 dB
endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MIN_PW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ctl = '0;
  logic       le = 1'b0;
  logic       pup = 1'b0;
  logic       clr = 1'b0;
  logic [4:0] state, half_db;
  logic       viol;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_atten_ctrl #(.SYNC_STAGES(2), .MIN_PW_CYC(MIN_PW)) i_step_atten_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ctl_i    (ctl),
    .le_i     (le),
    .pup_sel_i(pup),
    .pw_clr_i (clr),
    .state_o  (state),
    .half_db_o(half_db),
    .pw_viol_o(viol)
  );

  typedef struct packed {
    logic [4:0] word;
    logic [3:0] pw;
    logic       exp_viol;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'h00, 4'd1, 1'b1},
    '{5'h1F, 4'd4, 1'b0},
    '{5'h10, 4'd3, 1'b1},
    '{5'h01, 4'd5, 1'b0},
    '{5'h0A, 4'd2, 1'b1},
    '{5'h15, 4'd6, 1'b0},
    '{5'h08, 4'd4, 1'b0},
    '{5'h04, 4'd1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic le_pulse(input int n);
    @(negedge clk); le = 1'b1;
    cycles(n);
    le = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_reset(input logic le_v, input logic pup_v, input logic [4:0] w);
    @(negedge clk);
    rst_n = 1'b0; le = le_v; pup = pup_v; ctl = w;
    cycles(2);
    check("R5 state in reset", state, 0);
    check("R5 flag in reset", viol, 0);
    rst_n = 1'b1;
    cycles(2);
  endtask

  initial begin
    cycles(2);
    check("R5 state at start", state, 0);
    check("R5 flag at start", viol, 0);
    rst_n = 1'b1;
    cycles(4);
    check("R6 default select 0", state, 5'b00000);

    // latched loads from the vector table
    foreach (VECS[i]) begin
      @(negedge clk); ctl = VECS[i].word;
      cycles(3);
      clear_flag();
      le_pulse(int'(VECS[i].pw));
      cycles(4);
      ctl = ~VECS[i].word;  // R3: change while low must not reach state
      cycles(5);
      check("R4 latched word", state, VECS[i].word);
      check("R1 half-dB units", half_db, VECS[i].word);
      check("R9 pulse width flag", viol, VECS[i].exp_viol);
    end

    // R2: transparent following
    clear_flag();
    @(negedge clk); le = 1'b1; ctl = 5'h03;
    cycles(3);
    check("R2 follow 03", state, 5'h03);
    ctl = 5'h1C;
    cycles(2);
    check("R2 not yet at 2 edges", state, 5'h03);
    cycles(1);
    check("R2 follow 1C at third edge", state, 5'h1C);
    ctl = 5'h11;
    cycles(3);
    check("R2 follow 11", state, 5'h11);
    le = 1'b0;
    cycles(4);
    ctl = 5'h06;
    cycles(6);
    check("R3 hold after drop", state, 5'h11);
    check("R9 long pulse no flag", viol, 0);

    // R10: sticky flag
    le_pulse(2);
    cycles(4);
    check("R10 flag set", viol, 1);
    cycles(10);
    check("R10 flag sticky", viol, 1);
    check("R4 short pulse still loads", state, 5'h06);
    clear_flag();
    check("R10 flag cleared", viol, 0);

    // power-up defaults
    do_reset(1'b0, 1'b1, 5'h05);
    cycles(2);
    check("R7 default select 1", state, 5'b10000);
    do_reset(1'b0, 1'b0, 5'h1F);
    cycles(2);
    check("R6 default select 0", state, 5'b00000);
    do_reset(1'b1, 1'b1, 5'h05);
    cycles(2);
    check("R8 le high start", state, 5'h05);
    do_reset(1'b1, 1'b0, 5'h0B);
    cycles(2);
    check("R8 le high select ignored", state, 5'h0B);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule